// File: doc/BRIEF.md
# Hysteretic Lock Detector

The block watches a stream of signed error samples and decides whether a control loop has settled. Each sample is qualified by a valid strobe and compared, by magnitude, against a programmable threshold. A counter climbs toward a programmable lock count while samples stay inside the window. When the counter reaches that count, the locked flag is raised.

Samples outside the window walk the counter back down toward a lower release count. Only when the counter lands on that release count are the counter and the flag dropped to zero together. The gap between the two counts gives the flag hysteresis, so short bursts of noise do not drop lock.

The threshold and both counts may change at run time. A synchronous init input restarts the detector without a reset. Typical programming is a narrow window with about a thousand samples for frequency acquisition, and a wide window with about ten thousand samples for phase tracking.

Top module: `lock_hyst_det`

## Requirements
- R1: A valid sample is in range when its absolute value is less than or equal to `thresh_i`, which is read as unsigned; every other valid sample is out of range.
- R2: On an in-range valid sample, `count_o` increments by one when it is below `lock_cnt_i`; otherwise it is unchanged.
- R3: On an in-range valid sample, `locked_o` becomes 1 when the updated count equals `lock_cnt_i`; `locked_o` keeps its value otherwise.
- R4: On an out-of-range valid sample, `count_o` decrements by one when it is above `delock_cnt_i`.
- R5: On an out-of-range valid sample, if the updated count equals `delock_cnt_i`, then `count_o` becomes 0 and `locked_o` becomes 0 in the same cycle.
- R6: On an out-of-range valid sample, if the count is below `delock_cnt_i`, then `count_o` and `locked_o` are unchanged.
- R7: The magnitude of the most negative error value saturates to the largest positive value.
- R8: Results appear on the clock edge that samples `valid_i` high. When `valid_i` is low, `count_o` and `locked_o` hold their values.
- R9: `init_i` high clears `count_o` and `locked_o` on the next clock edge, with priority over `valid_i`.
- R10: `rst_ni` low clears `count_o` and `locked_o` at once, without waiting for a clock edge.
- R11: A new threshold or count value applies from the next valid sample. A count already above a lowered `lock_cnt_i` is not incremented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Synchronous restart |
| valid_i | input | 1 | Error sample strobe |
| err_i | input | ERR_W | Signed error sample |
| thresh_i | input | ERR_W | Unsigned in-range threshold |
| lock_cnt_i | input | CNT_W | Count at which lock is declared |
| delock_cnt_i | input | CNT_W | Count at which lock is released |
| locked_o | output | 1 | Lock flag |
| count_o | output | CNT_W | Current counter value |

## Verification
A wrong counter value shows on `count_o` on the first clock edge after the strobe that caused it. A wrong flag can stay hidden much longer: an early or missing release shows on `locked_o` only when the counter crosses one of the two programmed counts. For this reason the bench drives the counter through both counts, below the release count, and above a lowered lock count. It compares both outputs against a behavioural model on every clock, so a divergence is reported in the cycle it first appears.

// File: rtl/lock_hyst_pkg.sv
package lock_hyst_pkg;
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_IN   = 2'd1,
    EV_OUT  = 2'd2
  } lock_ev_e;
endpackage

// File: rtl/lock_hyst_mag.sv
module lock_hyst_mag #(
  parameter int ERR_W = 16
) (
  input  logic signed [ERR_W-1:0] err_i,
  input  logic        [ERR_W-1:0] thresh_i,
  output logic                    in_range_o
);
  localparam logic [ERR_W-1:0] MIN_NEG = {1'b1, {(ERR_W-1){1'b0}}};
  localparam logic [ERR_W-1:0] MAX_POS = {1'b0, {(ERR_W-1){1'b1}}};

  logic [ERR_W-1:0] mag;

  always_comb begin
    if (err_i == MIN_NEG)    mag = MAX_POS;  // saturate
    else if (err_i[ERR_W-1]) mag = -err_i;
    else                     mag = err_i;
  end

  assign in_range_o = (mag <= thresh_i);

  always_comb begin
    AST_MAG_POS: assert (!mag[ERR_W-1]); // R7
  end
endmodule

// File: rtl/lock_hyst_cnt.sv
module lock_hyst_cnt
  import lock_hyst_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  lock_ev_e         ev_i,
  input  logic [CNT_W-1:0] lock_cnt_i,
  input  logic [CNT_W-1:0] delock_cnt_i,
  output logic [CNT_W-1:0] count_o,
  output logic             locked_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_up, cnt_dn;
  logic             lk_q, lk_d;

  always_comb begin
    cnt_up = (cnt_q < lock_cnt_i)   ? cnt_q + ONE : cnt_q;
    cnt_dn = (cnt_q > delock_cnt_i) ? cnt_q - ONE : cnt_q;
    cnt_d  = cnt_q;
    lk_d   = lk_q;
    unique case (ev_i)
      EV_IN: begin
        cnt_d = cnt_up;
        if (cnt_up == lock_cnt_i) lk_d = 1'b1;
      end
      EV_OUT: begin
        if (cnt_dn == delock_cnt_i) begin
          cnt_d = '0;
          lk_d  = 1'b0;
        end else begin
          cnt_d = cnt_dn;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lk_q  <= 1'b0;
    end else if (init_i) begin
      cnt_q <= '0;
      lk_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lk_q  <= lk_d;
    end
  end

  assign count_o  = cnt_q;
  assign locked_o = lk_q;

  AST_INIT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (count_o == '0 && !locked_o)); // R9
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i == EV_NONE && !init_i) |=> ($stable(count_o) && $stable(locked_o))); // R8
  AST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i != EV_NONE && !init_i) |=> (count_o == '0 || count_o == $past(count_o)
      || count_o == $past(count_o) + ONE || count_o == $past(count_o) - ONE)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i == EV_IN && !init_i && cnt_q >= lock_cnt_i) |=> $stable(count_o)); // R2
  AST_LOCK_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> (count_o == $past(lock_cnt_i))); // R3
  AST_LOCK_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_o) |-> (count_o == '0)); // R5
endmodule

// File: rtl/lock_hyst_det.sv
module lock_hyst_det
  import lock_hyst_pkg::*;
#(
  parameter int ERR_W = 16,
  parameter int CNT_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    init_i,
  input  logic                    valid_i,
  input  logic signed [ERR_W-1:0] err_i,
  input  logic        [ERR_W-1:0] thresh_i,
  input  logic        [CNT_W-1:0] lock_cnt_i,
  input  logic        [CNT_W-1:0] delock_cnt_i,
  output logic                    locked_o,
  output logic        [CNT_W-1:0] count_o
);
  logic     in_range;
  lock_ev_e ev;

  lock_hyst_mag #(.ERR_W(ERR_W)) u_mag (
    .err_i     (err_i),
    .thresh_i  (thresh_i),
    .in_range_o(in_range)
  );

  always_comb begin
    if (!valid_i)      ev = EV_NONE;
    else if (in_range) ev = EV_IN;
    else               ev = EV_OUT;
  end

  lock_hyst_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .init_i      (init_i),
    .ev_i        (ev),
    .lock_cnt_i  (lock_cnt_i),
    .delock_cnt_i(delock_cnt_i),
    .count_o     (count_o),
    .locked_o    (locked_o)
  );

  AST_IN_RANGE_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !init_i && err_i == '0 && count_o < lock_cnt_i)
      |=> (count_o == $past(count_o) + 1'b1)); // R1
endmodule

// File: tb/lock_hyst_det_test.sv
module lock_hyst_det_test;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               init = 1'b0;
  logic               valid = 1'b0;
  logic signed [15:0] err = '0;
  logic        [15:0] thr = 16'd2;
  logic        [15:0] lock_n = 16'd10;
  logic        [15:0] delock_n = 16'd8;
  logic               locked;
  logic        [15:0] count;

  int    n_chk = 0, n_fail = 0, cycles = 0;
  int    m_cnt = 0;
  bit    m_lk = 0;
  string cur_req = "R10", edge_req = "R10";
  bit    done = 0;

  always #4 clk = ~clk;  // 125 MHz

  lock_hyst_det uut (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init), .valid_i(valid), .err_i(err),
    .thresh_i(thr), .lock_cnt_i(lock_n), .delock_cnt_i(delock_n),
    .locked_o(locked), .count_o(count)
  );

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_lk = 0;
    end else begin
      int e, mag, c;
      edge_req = cur_req;
      e = int'(err);
      mag = (e < 0) ? -e : e;
      if (mag > 32767) mag = 32767;
      if (init) begin
        m_cnt = 0; m_lk = 0;
      end else if (valid) begin
        c = m_cnt;
        if (mag <= int'(thr)) begin
          if (c < int'(lock_n)) c++;
          if (c == int'(lock_n)) m_lk = 1;
          m_cnt = c;
        end else begin
          if (c > int'(delock_n)) c--;
          if (c == int'(delock_n)) begin c = 0; m_lk = 0; end
          m_cnt = c;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_chk++;
      if (int'(count) != m_cnt || locked != m_lk) begin
        n_fail++;
        $display("FAIL %s: count=%0d locked=%0d expected count=%0d locked=%0d",
                 edge_req, count, locked, m_cnt, m_lk);
      end
    end
  end

  task automatic smp(input int e, input bit v);
    @(negedge clk);
    err = 16'(e); valid = v;
  endtask

  task automatic expect_cnt(input string r, input int c, input bit l);
    @(negedge clk);
    valid = 1'b0;
    #1;
    n_chk++;
    if (int'(count) != c || locked != l) begin
      n_fail++;
      $display("FAIL %s: count=%0d locked=%0d expected count=%0d locked=%0d",
               r, count, locked, c, l);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (count != 0 || locked) begin
      n_fail++;
      $display("FAIL R10: count=%0d locked=%0d expected 0 0", count, locked);
    end
    rst_n = 1'b1;

    cur_req = "R2";  // climb with in-range samples of both signs
    for (int i = 0; i < 9; i++) smp((i % 5) - 2, 1'b1);
    expect_cnt("R2", 9, 0);
    cur_req = "R3";
    for (int i = 0; i < 4; i++) smp(2 - i, 1'b1);
    expect_cnt("R3", 10, 1);

    cur_req = "R1";  // just outside the window
    smp(3, 1'b1);
    expect_cnt("R1", 9, 1);
    cur_req = "R5";
    smp(-3, 1'b1);
    expect_cnt("R5", 0, 0);

    cur_req = "R6";
    smp(100, 1'b1);
    expect_cnt("R6", 0, 0);
    for (int i = 0; i < 5; i++) smp(1, 1'b1);
    smp(-50, 1'b1);
    expect_cnt("R6", 5, 0);

    cur_req = "R4";
    for (int i = 0; i < 10; i++) smp(0, 1'b1);
    delock_n = 16'd3;
    smp(40, 1'b1); smp(40, 1'b1);
    expect_cnt("R4", 8, 1);

    cur_req = "R8";
    for (int i = 0; i < 6; i++) smp(i * 7, 1'b0);
    expect_cnt("R8", 8, 1);

    cur_req = "R11";
    lock_n = 16'd5;
    smp(0, 1'b1);
    expect_cnt("R11", 8, 1);
    thr = 16'd100;
    smp(60, 1'b1);
    expect_cnt("R11", 8, 1);

    cur_req = "R9";
    @(negedge clk); init = 1'b1; valid = 1'b1; err = '0;
    @(negedge clk); init = 1'b0; valid = 1'b0;
    expect_cnt("R9", 0, 0);

    cur_req = "R7";
    thr = 16'h7fff;
    smp(-32768, 1'b1);
    expect_cnt("R7", 1, 0);
    thr = 16'h7ffe;
    delock_n = 16'd0;
    smp(-32768, 1'b1);
    expect_cnt("R7", 0, 0);

    cur_req = "R3";  // wide window, long count
    thr = 16'd500; lock_n = 16'd1000; delock_n = 16'd990;
    for (int i = 0; i < 1000; i++) smp((i * 37) % 1001 - 500, 1'b1);
    expect_cnt("R3", 1000, 1);
    cur_req = "R5";
    for (int i = 0; i < 10; i++) smp(501, 1'b1);
    expect_cnt("R5", 0, 0);

    cur_req = "R10";
    for (int i = 0; i < 4; i++) smp(0, 1'b1);
    @(negedge clk); valid = 1'b0;
    #2 rst_n = 1'b0;
    #1;
    n_chk++;
    if (count != 0 || locked) begin
      n_fail++;
      $display("FAIL R10: count=%0d locked=%0d expected 0 0", count, locked);
    end
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule